// File: doc/BRIEF.md
# Indirect Byte-Wide Register Window

This block is a slave on an 8-bit bus. The bus can reach only two locations: an index register and a data window. The index selects one of a set of 32-bit internal registers, and the data window reads or writes that register one byte at a time. A select input chooses between the index and the window. Two address bits pick the byte lane of the 32-bit word. Reads are combinational while the chip select and the read strobe are both low. A write takes effect when the write strobe goes from low to high.

The internal registers are:
- an identifier register;
- a read-only word that gives the version and the highest table entry number;
- a read-only arbitration register that takes the identifier's value each time the identifier is written;
- a table of 64-bit entries. Each entry is mapped as two independent 32-bit halves.

The rest of the chip sees the whole table on a flat output bus. It also receives a one-cycle pulse each time the identifier is written.

The reset input is asynchronous and active low. Its release is synchronized into the clock domain. Strobe edges are detected by sampling the strobe on the clock.

Top module: `byte_index_window`

## Requirements
- R1: While reset is in effect (asynchronous assertion, plus the synchronizer stages after release), `data_oe` is 0. After reset, the index, the identifier, the arbitration value and every table word are zero.
- R2: A read is driven (`data_oe`=1) only while `cs_n`=0 and `rd_n`=0. `sel_data`=0 selects the index register and `sel_data`=1 selects the register the index points to. A write while `cs_n`=1 has no effect.
- R3: `addr` selects the byte lane: 0 is bits 7:0, 1 is bits 15:8, 2 is bits 23:16 and 3 is bits 31:24. A write commits on the first clock edge where `wr_n` is sampled high right after a low sample, with `cs_n`=0 at that edge. Only the addressed lane changes.
- R4: The index is 8 bits wide and sits in lane 0. Lanes 1 to 3 of the index read as zero, and writes to them are ignored.
- R5: Offset 00h is the identifier. It holds 4 bits in bits 27:24, which are bits 3:0 of lane 3. All its other bits read as zero and ignore writes.
- R6: Offset 01h reads 00170011h: the highest entry number (entries minus one) in bits 23:16 and version 11h in bits 7:0. Writes to it have no effect.
- R7: Offset 02h is the arbitration value in bits 27:24. It is read-only. A write to lane 3 of the identifier loads the same 4 bits into it, and `id_wr_pulse_o` is high for exactly the one cycle after that commit edge.
- R8: The low half of table entry n is at offset 10h+2n and the high half is at 11h+2n. Every bit can be read and written, one byte at a time. `tbl_o[64n+63:64n]` equals {high half, low half}.
- R9: Offsets 03h to 0Fh and 40h to FFh read as zero. Writes to them change no register and no table bit.
- R10: With `cs_n`=1 or `rd_n`=1, `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sel_data | input | 1 | 0 selects the index register, 1 selects the data window |
| addr | input | 2 | Byte lane within the 32-bit word |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; the write commits on its rising edge |
| data_in | input | 8 | Write data byte |
| data_out | output | 8 | Read data byte (zero when not driven) |
| data_oe | output | 1 | Output enable for the data bus |
| tbl_o | output | 1536 | Table contents, 64 bits per entry |
| id_wr_pulse_o | output | 1 | One-cycle pulse after an identifier write |

## Verification
The hardest case to reach is an ignored write. Examples are a byte written to a read-only word, to an unmapped index, to a reserved index lane, or with chip select high. Nothing changes at the ports when such a write is ignored. The stimulus therefore first fills the identifier and several table entries with distinct patterns. It then issues the ignored writes and afterwards re-reads the words that could have been hit, through the window, and compares the whole flat table output. This exposes any stray decode.

// File: rtl/ixw_pkg.sv
`timescale 1ns/1ps
package ixw_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ID_W   = 4;
  localparam int unsigned ID_LSB = 24;

  localparam logic [7:0] OFS_ID  = 8'h00;
  localparam logic [7:0] OFS_VER = 8'h01;
  localparam logic [7:0] OFS_ARB = 8'h02;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t lane_merge(word_t old, logic [1:0] lane, byte_t b);
    word_t w;
    w = old;
    case (lane)
      2'd0: w[7:0]   = b;
      2'd1: w[15:8]  = b;
      2'd2: w[23:16] = b;
      default: w[31:24] = b;
    endcase
    return w;
  endfunction

  function automatic byte_t lane_pick(word_t w, logic [1:0] lane);
    byte_t b;
    case (lane)
      2'd0: b = w[7:0];
      2'd1: b = w[15:8];
      2'd2: b = w[23:16];
      default: b = w[31:24];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/ixw_rst_sync.sv
`timescale 1ns/1ps
module ixw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_nxt = 1'b1;
    end else begin : g_many
      always_comb sh_nxt = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_nxt;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/ixw_wr_edge.sv
`timescale 1ns/1ps
module ixw_wr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  output logic commit_o
);
  logic wr_n_q;
  logic wr_n_nxt;

  always_comb wr_n_nxt = wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_n_q <= 1'b1;
    else        wr_n_q <= wr_n_nxt;
  end

  assign commit_o = !cs_n && wr_n && !wr_n_q;

  // R3: a strobe rise yields one commit, never two adjacent ones
  a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
endmodule

// File: rtl/ixw_ctrl_regs.sv
`timescale 1ns/1ps
module ixw_ctrl_regs
  import ixw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_i,
  input  logic            sel_data_i,
  input  logic [1:0]      lane_i,
  input  byte_t           wdata_i,
  output byte_t           index_o,
  output logic [ID_W-1:0] id_o,
  output logic [ID_W-1:0] arb_o,
  output logic            id_pulse_o
);
  byte_t           idx_q, idx_nxt;
  logic [ID_W-1:0] id_q, id_nxt, arb_q;
  logic            pulse_q;
  logic            idx_we, id_we;

  always_comb begin
    idx_we  = commit_i && !sel_data_i && (lane_i == 2'd0);
    id_we   = commit_i && sel_data_i && (idx_q == OFS_ID) && (lane_i == 2'd3);
    idx_nxt = wdata_i;
    id_nxt  = wdata_i[ID_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      id_q    <= '0;
      arb_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (idx_we) idx_q <= idx_nxt;
      if (id_we) begin
        id_q  <= id_nxt;
        arb_q <= id_nxt;
      end
      pulse_q <= id_we;
    end
  end

  assign index_o    = idx_q;
  assign id_o       = id_q;
  assign arb_o      = arb_q;
  assign id_pulse_o = pulse_q;

  // R4: the index moves only on a committed lane-0 index write
  a_r4_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_i && !sel_data_i) |=> $stable(idx_q));
  // R7: after the pulse, arbitration equals the identifier
  a_r7_arb_follows_id: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (arb_q == id_q));
  // R7: arbitration never moves without a commit
  a_r7_arb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(arb_q));
  // R7: the pulse lasts one cycle
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/ixw_entry_bank.sv
`timescale 1ns/1ps
module ixw_entry_bank
  import ixw_pkg::*;
#(
  parameter int unsigned N_ENT = 24,
  parameter logic [7:0]  BASE  = 8'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  byte_t              index_i,
  input  logic [1:0]         lane_i,
  input  byte_t              wdata_i,
  output logic               rd_hit_o,
  output word_t              rd_word_o,
  output logic [N_ENT*64-1:0] tbl_o
);
  localparam int unsigned N_WORDS   = 2 * N_ENT;
  localparam logic [8:0]  N_WORDS_W = 9'(N_WORDS);

  logic [N_WORDS-1:0][WORD_W-1:0] word_q;
  logic [8:0] rel;
  logic       in_range;

  always_comb begin
    rel      = {1'b0, index_i} - {1'b0, BASE};
    in_range = (index_i >= BASE) && (rel < N_WORDS_W);
  end

  generate
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      word_t q, nxt;
      logic  we;
      always_comb begin
        we  = wr_en_i && in_range && (rel == 9'(w));
        nxt = lane_merge(q, lane_i, wdata_i);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= nxt;
      end
      assign word_q[w] = q;
    end
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      assign tbl_o[e*64 +: 64] = {word_q[2*e+1], word_q[2*e]};
    end
  endgenerate

  always_comb begin
    rd_word_o = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (in_range && (rel == 9'(w))) rd_word_o = word_q[w];
    end
    rd_hit_o = in_range;
  end

  // R8: without a window write the table holds
  a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(tbl_o));
  // R9: a window write at an index outside the table leaves it untouched
  a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !in_range) |=> $stable(tbl_o));
endmodule

// File: rtl/byte_index_window.sv
`timescale 1ns/1ps
module byte_index_window
  import ixw_pkg::*;
#(
  parameter int unsigned N_ENT       = 24,
  parameter logic [7:0]  VERSION     = 8'h11,
  parameter logic [7:0]  TBL_BASE    = 8'h10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                cs_n,
  input  logic                sel_data,
  input  logic [1:0]          addr,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic [7:0]          data_in,
  output logic [7:0]          data_out,
  output logic                data_oe,
  output logic [N_ENT*64-1:0] tbl_o,
  output logic                id_wr_pulse_o
);
  localparam logic [7:0] MAX_ENT  = 8'(N_ENT - 1);
  localparam word_t      VER_WORD = {8'h00, MAX_ENT, 8'h00, VERSION};

  logic            rst_n_s;
  logic            commit;
  byte_t           index;
  logic [ID_W-1:0] id_val, arb_val;
  logic            bank_hit;
  word_t           bank_word;
  word_t           rd_word;

  ixw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n_s)
  );

  ixw_wr_edge u_edge (
    .clk(clk), .rst_n(rst_n_s), .cs_n(cs_n), .wr_n(wr_n), .commit_o(commit)
  );

  ixw_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .commit_i(commit), .sel_data_i(sel_data),
    .lane_i(addr), .wdata_i(data_in), .index_o(index), .id_o(id_val),
    .arb_o(arb_val), .id_pulse_o(id_wr_pulse_o)
  );

  ixw_entry_bank #(.N_ENT(N_ENT), .BASE(TBL_BASE)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .wr_en_i(commit && sel_data),
    .index_i(index), .lane_i(addr), .wdata_i(data_in),
    .rd_hit_o(bank_hit), .rd_word_o(bank_word), .tbl_o(tbl_o)
  );

  always_comb begin
    rd_word = '0;
    if (!sel_data) begin
      rd_word[7:0] = index;
    end else if (index == OFS_ID) begin
      rd_word[ID_LSB +: ID_W] = id_val;
    end else if (index == OFS_VER) begin
      rd_word = VER_WORD;
    end else if (index == OFS_ARB) begin
      rd_word[ID_LSB +: ID_W] = arb_val;
    end else if (bank_hit) begin
      rd_word = bank_word;
    end
  end

  assign data_oe  = rst_n_s && !cs_n && !rd_n;
  assign data_out = data_oe ? lane_pick(rd_word, addr) : 8'h00;

  // R2: a commit only happens while the chip is selected
  a_r2_commit_needs_cs: assert property (@(posedge clk) disable iff (!rst_n_s)
    commit |-> !cs_n);
endmodule

// File: tb/byte_index_window_tb_top.sv
`timescale 1ns/1ps
module byte_index_window_tb_top;
  localparam int N = 24;

  logic          clk = 1'b0;
  logic          arst_n;
  logic          cs_n, sel_data, rd_n, wr_n;
  logic [1:0]    addr;
  logic [7:0]    data_in;
  logic [7:0]    data_out;
  logic          data_oe;
  logic [N*64-1:0] tbl_o;
  logic          id_wr_pulse_o;

  always #10 clk = ~clk;

  byte_index_window dut_i (
    .clk(clk), .arst_n(arst_n), .cs_n(cs_n), .sel_data(sel_data),
    .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .tbl_o(tbl_o),
    .id_wr_pulse_o(id_wr_pulse_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic        mon_en = 1'b0;

  logic [7:0]  m_idx;
  logic [3:0]  m_id;
  logic [31:0] m_tbl [2*N];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard while a read is on the bus
  always @(posedge clk) begin
    #5;
    if (mon_en) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(data_oe === 1'b1, {t, " oe"}, {63'd0, data_oe}, 64'd1);
      chk(data_out === e, t, {56'd0, data_out}, {56'd0, e});
    end
  end

  task automatic wr_byte(input logic sel, input logic [1:0] a, input logic [7:0] d, input logic sel_chip);
    @(negedge clk);
    cs_n = !sel_chip; sel_data = sel; addr = a; data_in = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic rd_byte(input logic sel, input logic [1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    cs_n = 1'b0; sel_data = sel; addr = a; rd_n = 1'b0; mon_en = 1'b1;
    @(negedge clk);
    mon_en = 1'b0; rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic set_index(input logic [7:0] v);
    wr_byte(1'b0, 2'd0, v, 1'b1);
    m_idx = v;
  endtask

  function automatic logic [31:0] model_word(input logic [7:0] ix);
    logic [31:0] w;
    w = '0;
    if (ix == 8'h00) w[27:24] = m_id;
    else if (ix == 8'h01) w = 32'h0017_0011;
    else if (ix == 8'h02) w[27:24] = m_id;
    else if (ix >= 8'h10 && ix < 8'h10 + 2*N) w = m_tbl[ix - 8'h10];
    return w;
  endfunction

  task automatic rd_word_chk(input logic [7:0] ix, input string t);
    logic [31:0] w;
    w = model_word(ix);
    for (int l = 0; l < 4; l++) rd_byte(1'b1, 2'(l), w[8*l +: 8], t);
  endtask

  task automatic tbl_chk(input string t);
    logic [N*64-1:0] e;
    for (int k = 0; k < N; k++) e[64*k +: 64] = {m_tbl[2*k+1], m_tbl[2*k]};
    n_chk++;
    if (tbl_o !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", t, tbl_o, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_idx = 0; m_id = 0;
    for (int k = 0; k < 2*N; k++) m_tbl[k] = '0;
    arst_n = 1'b0; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
    sel_data = 1'b0; addr = 2'd0; data_in = 8'h00;
    repeat (3) @(negedge clk);
    chk(data_oe === 1'b0, "R1 oe in reset", {63'd0, data_oe}, 64'd0);
    arst_n = 1'b1;
    @(negedge clk);
    chk(data_oe === 1'b0, "R1 oe in sync stage", {63'd0, data_oe}, 64'd0);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    rd_byte(1'b0, 2'd0, 8'h00, "R1 index reset");
    rd_word_chk(8'h00, "R1 id reset");
    tbl_chk("R1 table reset");

    // R10 no drive when not selected or not reading
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk(data_oe === 1'b0, "R10 cs high", {63'd0, data_oe}, 64'd0);
    cs_n = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    chk(data_oe === 1'b0, "R10 rd high", {63'd0, data_oe}, 64'd0);
    cs_n = 1'b1;

    // R6 version word, and writes to it ignored
    set_index(8'h01);
    rd_byte(1'b0, 2'd0, 8'h01, "R2 index readback");
    rd_word_chk(8'h01, "R6 version");
    for (int l = 0; l < 4; l++) wr_byte(1'b1, 2'(l), 8'hFF, 1'b1);
    rd_word_chk(8'h01, "R6 version after write");

    // R5 / R7 identifier and arbitration
    set_index(8'h00);
    chk(id_wr_pulse_o === 1'b0, "R7 no pulse on index write", {63'd0, id_wr_pulse_o}, 64'd0);
    wr_byte(1'b1, 2'd3, 8'hA5, 1'b1);
    m_id = 4'h5;
    chk(id_wr_pulse_o === 1'b1, "R7 pulse high", {63'd0, id_wr_pulse_o}, 64'd1);
    @(negedge clk);
    chk(id_wr_pulse_o === 1'b0, "R7 pulse one cycle", {63'd0, id_wr_pulse_o}, 64'd0);
    for (int l = 0; l < 3; l++) wr_byte(1'b1, 2'(l), 8'hFF, 1'b1);
    rd_word_chk(8'h00, "R5 id word");
    set_index(8'h02);
    rd_word_chk(8'h02, "R7 arb follows id");
    for (int l = 0; l < 4; l++) wr_byte(1'b1, 2'(l), 8'h0C, 1'b1);
    rd_word_chk(8'h02, "R7 arb read-only");

    // R4 index upper lanes
    wr_byte(1'b0, 2'd1, 8'hFF, 1'b1);
    wr_byte(1'b0, 2'd3, 8'h3C, 1'b1);
    for (int l = 0; l < 4; l++)
      rd_byte(1'b0, 2'(l), (l == 0) ? m_idx : 8'h00, "R4 index lanes");

    // R8 / R3 table, several entries, byte lanes
    foreach (m_tbl[k]) begin end
    for (int s = 0; s < 4; s++) begin
      int e;
      e = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 11 : N - 1;
      for (int h = 0; h < 2; h++) begin
        set_index(8'(8'h10 + 2*e + h));
        for (int l = 0; l < 4; l++) begin
          logic [7:0] b;
          b = 8'(e * 16 + h * 8 + l + 8'h41);
          wr_byte(1'b1, 2'(l), b, 1'b1);
          m_tbl[2*e+h][8*l +: 8] = b;
        end
        rd_word_chk(8'(8'h10 + 2*e + h), "R8 table word");
      end
      tbl_chk("R8 table flat");
    end
    // R3 single-lane write on entry 11 high half
    set_index(8'h10 + 2*11 + 1);
    wr_byte(1'b1, 2'd2, 8'h5A, 1'b1);
    m_tbl[23][23:16] = 8'h5A;
    rd_word_chk(8'h10 + 2*11 + 1, "R3 lane only");
    tbl_chk("R3 lane only flat");

    // R9 unmapped offsets
    set_index(8'h05);
    for (int l = 0; l < 4; l++) wr_byte(1'b1, 2'(l), 8'hEE, 1'b1);
    rd_word_chk(8'h05, "R9 unmapped low");
    set_index(8'h40);
    for (int l = 0; l < 4; l++) wr_byte(1'b1, 2'(l), 8'hEE, 1'b1);
    rd_word_chk(8'h40, "R9 unmapped 40h");
    set_index(8'hFF);
    wr_byte(1'b1, 2'd3, 8'hEE, 1'b1);
    rd_word_chk(8'hFF, "R9 unmapped FFh");
    tbl_chk("R9 table untouched");
    set_index(8'h00);
    rd_word_chk(8'h00, "R9 id untouched");

    // R2 write with chip select high is ignored
    wr_byte(1'b0, 2'd0, 8'h12, 1'b0);
    rd_byte(1'b0, 2'd0, 8'h00, "R2 cs high write index");
    wr_byte(1'b1, 2'd3, 8'h07, 1'b0);
    rd_word_chk(8'h00, "R2 cs high write id");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule